// File: doc/BRIEF.md
# SDRAM Bank Close Scheduler

This block keeps track of which of the SDRAM banks hold an open row and issues the command that closes them. A requester raises a close request that names one bank, or that asks for every bank at once. The block grants the request in the cycle that the write-recovery rules allow. It then drives the close command on the command pins in the following cycle. After a bank is closed it stays locked for a programmable number of clocks. Any activate to that bank during this time is not accepted.

Another part of the controller issues the activate commands and the write data. That controller reports each activate and each write data beat to this block. From these reports the block learns which banks are open and when each one last received data. The command pins show a no-operation in every cycle that does not carry a close command.

Top module: `sdram_pre_sched`

## Requirements
- R1: During reset and in the first cycle after it, the pins show NOP, every bank reads as idle, and no bank reads as busy.
- R2: A cycle that follows a cycle with no grant shows NOP on the pins. NOP is cs_n=0, ras_n=1, cas_n=1, we_n=1.
- R3: In the cycle after a single-bank grant, the pins show PRECHARGE with a10=0 and ba equal to the granted bank. PRECHARGE is cs_n=0, ras_n=0, cas_n=1, we_n=0.
- R4: In the cycle after an all-bank grant (pre_all=1), the pins show PRECHARGE with a10=1 and ba=0, and every bank reads as idle.
- R5: Suppose a write beat reaches an open bank in cycle t. A single-bank request to that bank is not granted before cycle t+TWR. It is granted in cycle t+TWR if no further beat reaches that bank. A beat in the same cycle as the request also blocks the grant.
- R6: An all-bank request is granted only in a cycle where every bank has met its write recovery, including against beats in that same cycle.
- R7: Suppose PRECHARGE appears on the pins in cycle p. Until cycle p+TRP, bank_busy is high for the closed bank and an activate to it is ignored. An activate in cycle p+TRP opens the bank.
- R8: An accepted activate sets bank_open one cycle later. An activate to a bank in the same cycle as a grant that closes that bank is ignored.
- R9: A write beat to an idle bank is ignored. It neither makes the bank busy nor delays a grant.
- R10: A request that closes a bank that is already idle is still granted, and it restarts that bank's TRP lockout.
- R11: pre_gnt is never high while pre_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_valid | input | 1 | An activate is being issued this cycle |
| act_bank | input | 2 | Bank of that activate |
| wr_beat | input | 1 | A write data beat is on the bus this cycle |
| wr_bank | input | 2 | Bank that the beat belongs to |
| pre_req | input | 1 | Close request, held until granted |
| pre_all | input | 1 | Request closes all banks |
| pre_bank | input | 2 | Bank to close when pre_all is low |
| pre_gnt | output | 1 | Request accepted this cycle |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| a10 | output | 1 | All-bank flag |
| bank_open | output | 4 | Bank holds an open row |
| bank_busy | output | 4 | Bank is in write recovery or TRP lockout |

## Verification
A write beat and a close request can reach the same bank in the same cycle. The same happens when a beat meets an all-bank request. An activate and a close can also collide on one bank. The bench provokes these collisions with directed cycles and, in large numbers, with random traffic in which beats, activates and requests overlap freely. A reference model tracks per-bank open state and recovery windows. It judges every grant, every pin cycle and the open and busy vectors, so a grant given one cycle early or one cycle late is caught.

// File: rtl/sdram_pre_sched.sv
module sdram_pre_sched #(
  parameter int NB  = 4,
  parameter int TRP = 3,
  parameter int TWR = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  act_valid,
  input  logic [$clog2(NB)-1:0] act_bank,
  input  logic                  wr_beat,
  input  logic [$clog2(NB)-1:0] wr_bank,
  input  logic                  pre_req,
  input  logic                  pre_all,
  input  logic [$clog2(NB)-1:0] pre_bank,
  output logic                  pre_gnt,
  output logic                  cs_n,
  output logic                  ras_n,
  output logic                  cas_n,
  output logic                  we_n,
  output logic [$clog2(NB)-1:0] ba,
  output logic                  a10,
  output logic [NB-1:0]         bank_open,
  output logic [NB-1:0]         bank_busy
);
  localparam int BAW = $clog2(NB);
  localparam int MX  = (TRP > TWR) ? TRP : TWR;
  localparam int CW  = $clog2(MX + 1);

  logic [CW-1:0] lock_cnt [NB];
  logic [CW-1:0] rec_cnt  [NB];
  logic [NB-1:0] open_q, rec_ok, hit;
  logic          pre_q, a10_q;
  logic [BAW-1:0] ba_q;

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      rec_ok[b]    = (rec_cnt[b] == '0) &&
                     !(wr_beat && wr_bank == BAW'(b) && open_q[b]);
      bank_busy[b] = (lock_cnt[b] != '0) || (rec_cnt[b] != '0);
    end
  end

  assign pre_gnt = pre_req && (pre_all ? (&rec_ok) : rec_ok[pre_bank]);

  always_comb
    for (int b = 0; b < NB; b++)
      hit[b] = pre_gnt && (pre_all || pre_bank == BAW'(b));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= '0;
      for (int b = 0; b < NB; b++) begin
        lock_cnt[b] <= '0;
        rec_cnt[b]  <= '0;
      end
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (hit[b]) begin
          open_q[b]   <= 1'b0;
          lock_cnt[b] <= CW'(TRP);
        end else begin
          if (act_valid && act_bank == BAW'(b) && lock_cnt[b] == '0)
            open_q[b] <= 1'b1;
          if (lock_cnt[b] != '0)
            lock_cnt[b] <= lock_cnt[b] - 1'b1;
        end
        if (wr_beat && wr_bank == BAW'(b) && open_q[b])
          rec_cnt[b] <= CW'(TWR - 1);
        else if (rec_cnt[b] != '0)
          rec_cnt[b] <= rec_cnt[b] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= 1'b0;
      a10_q <= 1'b0;
      ba_q  <= '0;
    end else begin
      pre_q <= pre_gnt;
      a10_q <= pre_gnt && pre_all;
      ba_q  <= (pre_gnt && !pre_all) ? pre_bank : '0;
    end
  end

  assign cs_n      = 1'b0;
  assign ras_n     = !pre_q;
  assign cas_n     = 1'b1;
  assign we_n      = !pre_q;
  assign ba        = ba_q;
  assign a10       = a10_q;
  assign bank_open = open_q;
endmodule

module sdram_pre_sched_chk #(
  parameter int NB = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_beat,
  input logic [$clog2(NB)-1:0] wr_bank,
  input logic                  pre_req,
  input logic                  pre_all,
  input logic [$clog2(NB)-1:0] pre_bank,
  input logic                  pre_gnt,
  input logic                  cs_n,
  input logic                  ras_n,
  input logic                  cas_n,
  input logic                  we_n,
  input logic [$clog2(NB)-1:0] ba,
  input logic                  a10,
  input logic [NB-1:0]         bank_open,
  input logic [NB-1:0]         bank_busy
);
  logic armed;
  always_ff @(posedge clk)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  // R2
  nop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(pre_gnt) |-> !cs_n && ras_n && cas_n && we_n);

  // R3
  pre_encode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(pre_gnt) |-> !cs_n && !ras_n && cas_n && !we_n);

  // R4
  all_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(pre_gnt && pre_all) |-> a10 && ba == '0 && bank_open == '0);

  // R7
  lock_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !ras_n && !we_n && !a10 |-> bank_busy[ba] && !bank_open[ba]);

  // R5
  beat_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_gnt && !pre_all && wr_beat && wr_bank == pre_bank |-> !bank_open[pre_bank]);

  // R6
  all_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_gnt && pre_all && wr_beat |-> !bank_open[wr_bank]);

  // R11
  gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_gnt |-> pre_req);
endmodule

bind sdram_pre_sched sdram_pre_sched_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_beat(wr_beat), .wr_bank(wr_bank),
  .pre_req(pre_req), .pre_all(pre_all), .pre_bank(pre_bank),
  .pre_gnt(pre_gnt), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .a10(a10), .bank_open(bank_open),
  .bank_busy(bank_busy));

// File: tb/sdram_pre_sched_bench.sv
module sdram_pre_sched_bench;
  localparam int NB = 4, TRP = 3, TWR = 2;

  logic clk = 0, rst_n = 0;
  logic act_valid = 0, wr_beat = 0, pre_req = 0, pre_all = 0;
  logic [1:0] act_bank = 0, wr_bank = 0, pre_bank = 0;
  logic pre_gnt, cs_n, ras_n, cas_n, we_n, a10;
  logic [1:0] ba;
  logic [3:0] bank_open, bank_busy;

  int checks = 0, failures = 0;
  int m_trp [NB];
  int m_wr  [NB];
  bit m_open [NB];
  bit m_pre, m_a10, last_gnt;
  int m_ba;

  always #5 clk = ~clk;

  sdram_pre_sched #(.NB(NB), .TRP(TRP), .TWR(TWR)) u_sdram_pre_sched (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_bank(act_bank),
    .wr_beat(wr_beat), .wr_bank(wr_bank), .pre_req(pre_req),
    .pre_all(pre_all), .pre_bank(pre_bank), .pre_gnt(pre_gnt),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba),
    .a10(a10), .bank_open(bank_open), .bank_busy(bank_busy));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_open();
    int v = 0;
    for (int b = 0; b < NB; b++) if (m_open[b]) v |= (1 << b);
    return v;
  endfunction

  function automatic int exp_busy();
    int v = 0;
    for (int b = 0; b < NB; b++) if (m_trp[b] != 0 || m_wr[b] != 0) v |= (1 << b);
    return v;
  endfunction

  function automatic bit exp_grant(bit w_v, int w_b, bit p_r, bit p_a, int p_b);
    bit ok [NB];
    bit all = 1;
    for (int b = 0; b < NB; b++) begin
      ok[b] = (m_wr[b] == 0) && !(w_v && w_b == b && m_open[b]);
      all &= ok[b];
    end
    return p_r && (p_a ? all : ok[p_b]);
  endfunction

  task automatic cyc(input bit a_v, input int a_b, input bit w_v, input int w_b,
                     input bit p_r, input bit p_a, input int p_b);
    bit eg;
    @(negedge clk);
    chk(m_pre ? (m_a10 ? "R4" : "R3") : "R2",
        {cs_n, ras_n, cas_n, we_n}, m_pre ? 4'b0010 : 4'b0111);
    chk(m_a10 ? "R4" : "R3", {a10, ba}, {m_a10, 2'(m_ba)});
    chk("R8", bank_open, exp_open());
    chk("R7", bank_busy, exp_busy());
    act_valid = a_v; act_bank = 2'(a_b); wr_beat = w_v; wr_bank = 2'(w_b);
    pre_req = p_r; pre_all = p_a; pre_bank = 2'(p_b);
    #1;
    eg = exp_grant(w_v, w_b, p_r, p_a, p_b);
    chk(!p_r ? "R11" : (p_a ? "R6" : "R5"), pre_gnt, eg);
    last_gnt = pre_gnt;
    for (int b = 0; b < NB; b++) begin
      bit hit = eg && (p_a || p_b == b);
      if (w_v && w_b == b && m_open[b]) m_wr[b] = TWR - 1;
      else if (m_wr[b] > 0) m_wr[b]--;
      if (hit) begin
        m_open[b] = 0; m_trp[b] = TRP;
      end else begin
        if (a_v && a_b == b && m_trp[b] == 0) m_open[b] = 1;
        if (m_trp[b] > 0) m_trp[b]--;
      end
    end
    m_pre = eg; m_a10 = eg && p_a; m_ba = (eg && !p_a) ? p_b : 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic peek();
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    for (int b = 0; b < NB; b++) begin m_trp[b] = 0; m_wr[b] = 0; m_open[b] = 0; end
    m_pre = 0; m_a10 = 0; m_ba = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk("R1", bank_open, 0);
    @(negedge clk) rst_n = 1;
    #1;
    chk("R1", bank_busy, 0);

    // R9: beat to idle bank 2
    cyc(0, 0, 1, 2, 0, 0, 0);
    peek();
    chk("R9", bank_busy[2], 0);
    // R10: close idle bank 2
    cyc(0, 0, 0, 0, 1, 0, 2);
    chk("R10", last_gnt, 1);
    peek();
    chk("R10", bank_busy[2], 1);

    // R5: open bank 1, two beats, beat collides with request
    cyc(1, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 1, 0, 0, 0);
    cyc(0, 0, 1, 1, 1, 0, 1);
    chk("R5", last_gnt, 0);
    n = 0;
    do begin cyc(0, 0, 0, 0, 1, 0, 1); n++; end while (!last_gnt && n < 20);
    chk("R5", n, TWR);

    // R7: count activate attempts until bank 1 opens
    n = 0;
    do begin cyc(1, 1, 0, 0, 0, 0, 0); peek(); n++; end while (!bank_open[1] && n < 20);
    chk("R7", n, TRP + 1);

    // R6: open banks 0 and 3, beat on 3, close all
    idle(TRP);
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(1, 3, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 3, 1, 1, 0);
    chk("R6", last_gnt, 0);
    n = 0;
    do begin cyc(0, 0, 0, 0, 1, 1, 0); n++; end while (!last_gnt && n < 20);
    chk("R6", n, TWR);
    peek();
    chk("R4", bank_open, 0);

    // R8: activate colliding with close of the same bank
    idle(TRP);
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 1, 0, 0);
    peek();
    chk("R8", bank_open[0], 0);

    // random traffic
    n = $urandom(32'd1234);
    for (int i = 0; i < 4000; i++) begin
      bit pr = ($urandom % 4) == 0;
      cyc(($urandom % 3) == 0, $urandom % 4, ($urandom % 3) == 0, $urandom % 4,
          pr, pr && (($urandom % 5) == 0), $urandom % 4);
    end
    idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule